// File: doc/BRIEF.md
# Multichannel Audio Sample Distributor

This block sits between a memory read stream and a bank of serial audio output lanes. It takes a linear stream of sample words, one word for each sample, read from consecutive memory locations. It spreads them across one to four output lanes. Each lane has a left slot and a right slot. In stereo mode the words fill lane 0 left, lane 0 right, lane 1 left, lane 1 right and so on. In mono mode they fill only the left slots, one lane after another. While it consumes words, the block keeps a byte read index that stands in for address generation.

Each sample is put together on the fly. A byte-order control picks how the memory bytes form a 16- or 32-bit value. In 32-bit format the upper half of that value is kept. A sign-conversion control can flip the most significant bit, which turns offset-binary data into two's complement. The block gathers a whole frame in a staging bank and then stops accepting words. A downstream serializer pulses a frame request. On that request the block hands over the staged frame, or raises an underrun with silent samples if the frame is still incomplete.

Top module: `audio_lane_distributor`

## Requirements
- R1: After reset, word_ready_o is 1, rd_addr_o is 0, frame_valid_o is 0, underrun_o is 0 and every left and right output is 0.
- R2: Each accepted word advances rd_addr_o by 2 in 16-bit format (cfg_fmt32_i=0) or by 4 in 32-bit format (cfg_fmt32_i=1), so successive reads use strictly increasing addresses.
- R3: With cfg_stereo_i=1, successive samples of a frame go to lane 0 left, lane 0 right, lane 1 left, lane 1 right, and so on up to the last active lane.
- R4: With cfg_stereo_i=0, successive samples go to the left slots of lane 0, 1, 2, and so on, and every right slot is 0.
- R5: cfg_lanes_i values 0 to 3 make lanes 0..cfg_lanes_i active. Left and right slots of the other lanes are 0 in every frame.
- R6: In 16-bit format, word_i[7:0] is the byte at the lower address and word_i[15:8] the next byte, and word_i[31:16] is ignored. cfg_le_i=1 gives sample {word_i[15:8],word_i[7:0]}. cfg_le_i=0 gives {word_i[7:0],word_i[15:8]}.
- R7: In 32-bit format, word_i[8i+7:8i] is the byte at address offset i. The output is the upper 16 bits of the assembled word: {word_i[31:24],word_i[23:16]} when cfg_le_i=1 and {word_i[7:0],word_i[15:8]} when cfg_le_i=0.
- R8: With cfg_sign_i=1, bit 15 of every fed sample is inverted. Slots that are not fed stay 0.
- R9: When a frame is complete, word_ready_o drops to 0. A frame_req_i pulse then gives frame_valid_o=1 for one cycle in the next cycle, with the frame on the outputs and underrun_o=0. After that word_ready_o returns to 1.
- R10: A frame_req_i pulse while the frame is incomplete gives frame_valid_o=1 with underrun_o=1 and all outputs 0 in the next cycle. Samples already collected stay in the staging bank for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_lanes_i | input | LANE_W | Active lane count minus one |
| cfg_stereo_i | input | 1 | 1 = stereo order, 0 = mono order |
| cfg_fmt32_i | input | 1 | 1 = 32-bit samples, 0 = 16-bit samples |
| cfg_le_i | input | 1 | 1 = little-endian byte order |
| cfg_sign_i | input | 1 | Invert sample MSB |
| word_i | input | 2*SAMP_W | Memory word holding one sample |
| word_valid_i | input | 1 | word_i is valid |
| word_ready_o | output | 1 | Block accepts a word this cycle |
| rd_addr_o | output | ADDR_W | Byte read index of the next word |
| frame_req_i | input | 1 | Downstream asks for the next frame |
| frame_valid_o | output | 1 | One-cycle frame delivery strobe |
| underrun_o | output | 1 | Delivered frame was incomplete |
| left_o | output | LANES*SAMP_W | Left samples, lane l at [l*SAMP_W +: SAMP_W] |
| right_o | output | LANES*SAMP_W | Right samples, lane l at [l*SAMP_W +: SAMP_W] |

## Verification
An accepted word shows its effect in rd_addr_o and in the staging bank one clock edge after the edge that takes it. word_ready_o falls in that same cycle, after the last word of a frame. A frame request sampled at an edge puts frame_valid_o, underrun_o and the frame data on the outputs immediately after that edge, and frame_valid_o clears one edge later. The bench drives every input on the falling edge and checks each result on the next falling edge after the rising edge that produces it. It sweeps all lane counts, modes, formats, byte orders and sign settings.

// File: rtl/alsd_pkg.sv
package alsd_pkg;
  localparam int SAMP_W = 16;
  localparam int WORD_W = 2 * SAMP_W;
  typedef logic [SAMP_W-1:0] sample_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/alsd_unpack.sv
module alsd_unpack
  import alsd_pkg::*;
(
  input  word_t   word_i,
  input  logic    fmt32_i,
  input  logic    le_i,
  input  logic    sign_i,
  output sample_t sample_o
);
  localparam int NB_W = WORD_W / 8;
  localparam int NB_S = SAMP_W / 8;

  word_t   rev_w;
  sample_t rev_s;
  sample_t raw;

  // byte swap of full word and of the low sample
  always_comb begin
    for (int b = 0; b < NB_W; b++) rev_w[b*8 +: 8] = word_i[(NB_W-1-b)*8 +: 8];
    for (int b = 0; b < NB_S; b++) rev_s[b*8 +: 8] = word_i[(NB_S-1-b)*8 +: 8];
  end

  always_comb begin
    if (fmt32_i) raw = le_i ? word_i[WORD_W-1 -: SAMP_W] : rev_w[WORD_W-1 -: SAMP_W];
    else         raw = le_i ? word_i[SAMP_W-1:0]        : rev_s;
    sample_o = raw;
    sample_o[SAMP_W-1] = raw[SAMP_W-1] ^ sign_i;
  end
endmodule

// File: rtl/alsd_collect.sv
module alsd_collect
  import alsd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANE_W-1:0] cfg_lanes_i,
  input  logic              cfg_stereo_i,
  input  logic              cfg_fmt32_i,
  input  sample_t           sample_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              release_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              full_o,
  output sample_t           stage_l_o [LANES],
  output sample_t           stage_r_o [LANES]
);
  localparam int CNT_W = $clog2(2 * LANES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  act;
  logic [CNT_W-1:0]  needed;
  logic [CNT_W-1:0]  lane_idx;
  logic              to_right;
  logic              accept;
  logic [ADDR_W-1:0] step;
  sample_t           stl_q [LANES];
  sample_t           str_q [LANES];

  always_comb begin
    act = CNT_W'(cfg_lanes_i) + CNT_W'(1);
    if (act > CNT_W'(LANES)) act = CNT_W'(LANES);
    needed   = cfg_stereo_i ? (act << 1) : act;
    lane_idx = cfg_stereo_i ? (cnt_q >> 1) : cnt_q;
    to_right = cfg_stereo_i & cnt_q[0];
    step     = cfg_fmt32_i ? ADDR_W'(4) : ADDR_W'(2);
  end

  assign full_o  = (cnt_q >= needed);
  assign ready_o = ~full_o;
  assign accept  = valid_i & ready_o;
  assign addr_o  = addr_q;

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= addr_q + step;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (release_i && full_o) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stl_q[l] <= '0;
        str_q[l] <= '0;
      end else if (release_i && full_o) begin
        stl_q[l] <= '0;
        str_q[l] <= '0;
      end else if (accept && lane_idx == CNT_W'(l)) begin
        if (to_right) str_q[l] <= sample_i;
        else          stl_q[l] <= sample_i;
      end
    end
    assign stage_l_o[l] = stl_q[l];
    assign stage_r_o[l] = str_q[l];
  end

  assert_addr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (addr_q == $past(addr_q) + $past(step)));

  assert_addr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(addr_q));

  assert_no_overfill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> (cnt_q <= $past(needed)));

  assert_mono_right_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !cfg_stereo_i) |=> $stable(str_q[0]));
endmodule

// File: rtl/alsd_frame_out.sv
module alsd_frame_out
  import alsd_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    full_i,
  input  sample_t stage_l_i [LANES],
  input  sample_t stage_r_i [LANES],
  output logic    valid_o,
  output logic    underrun_o,
  output sample_t out_l_o [LANES],
  output sample_t out_r_o [LANES]
);
  sample_t ol_q [LANES];
  sample_t or_q [LANES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      underrun_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) underrun_o <= ~full_i;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ol_q[l] <= '0;
        or_q[l] <= '0;
      end else if (req_i) begin
        ol_q[l] <= full_i ? stage_l_i[l] : '0;
        or_q[l] <= full_i ? stage_r_i[l] : '0;
      end
    end
    assign out_l_o[l] = ol_q[l];
    assign out_r_o[l] = or_q[l];

    assert_underrun_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underrun_o |-> (ol_q[l] == '0 && or_q[l] == '0));
  end

  assert_valid_after_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(req_i));

  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !full_i) |=> (valid_o && underrun_o));
endmodule

// File: rtl/audio_lane_distributor.sv
module audio_lane_distributor
  import alsd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  parameter int ADDR_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANE_W-1:0]         cfg_lanes_i,
  input  logic                      cfg_stereo_i,
  input  logic                      cfg_fmt32_i,
  input  logic                      cfg_le_i,
  input  logic                      cfg_sign_i,
  input  logic [2*SAMP_W-1:0]       word_i,
  input  logic                      word_valid_i,
  output logic                      word_ready_o,
  output logic [ADDR_W-1:0]         rd_addr_o,
  input  logic                      frame_req_i,
  output logic                      frame_valid_o,
  output logic                      underrun_o,
  output logic [LANES*SAMP_W-1:0]   left_o,
  output logic [LANES*SAMP_W-1:0]   right_o
);
  sample_t smp;
  logic    full;
  sample_t stage_l [LANES];
  sample_t stage_r [LANES];
  sample_t out_l   [LANES];
  sample_t out_r   [LANES];

  alsd_unpack u_unpack (
    .word_i   (word_i),
    .fmt32_i  (cfg_fmt32_i),
    .le_i     (cfg_le_i),
    .sign_i   (cfg_sign_i),
    .sample_o (smp)
  );

  alsd_collect #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_collect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_lanes_i  (cfg_lanes_i),
    .cfg_stereo_i (cfg_stereo_i),
    .cfg_fmt32_i  (cfg_fmt32_i),
    .sample_i     (smp),
    .valid_i      (word_valid_i),
    .ready_o      (word_ready_o),
    .release_i    (frame_req_i),
    .addr_o       (rd_addr_o),
    .full_o       (full),
    .stage_l_o    (stage_l),
    .stage_r_o    (stage_r)
  );

  alsd_frame_out #(.LANES(LANES)) u_frame_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (frame_req_i),
    .full_i     (full),
    .stage_l_i  (stage_l),
    .stage_r_i  (stage_r),
    .valid_o    (frame_valid_o),
    .underrun_o (underrun_o),
    .out_l_o    (out_l),
    .out_r_o    (out_r)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_flat
    assign left_o [l*SAMP_W +: SAMP_W] = out_l[l];
    assign right_o[l*SAMP_W +: SAMP_W] = out_r[l];

    assert_unfed_lane_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_valid_o && (l > int'(cfg_lanes_i))) |-> (out_l[l] == '0 && out_r[l] == '0));

    assert_mono_right_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_valid_o && !cfg_stereo_i) |-> (out_r[l] == '0));
  end

  assert_ready_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !frame_req_i) |=> !word_ready_o);
endmodule

// File: tb/audio_lane_distributor_bench.sv
module audio_lane_distributor_bench;
  localparam int LANES = 4;
  localparam int SW    = 16;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [1:0]            cfg_lanes = '0;
  logic                  cfg_stereo = 1'b0, cfg_fmt32 = 1'b0, cfg_le = 1'b0, cfg_sign = 1'b0;
  logic [31:0]           word = '0;
  logic                  word_valid = 1'b0;
  logic                  word_ready;
  logic [15:0]           rd_addr;
  logic                  frame_req = 1'b0;
  logic                  frame_valid;
  logic                  underrun;
  logic [LANES*SW-1:0]   left, right;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_addr = '0;
  logic [15:0] exp_l [LANES];
  logic [15:0] exp_r [LANES];

  always #10 clk = ~clk;

  audio_lane_distributor u_audio_lane_distributor (
    .clk_i(clk), .rst_ni(rst_n), .cfg_lanes_i(cfg_lanes), .cfg_stereo_i(cfg_stereo),
    .cfg_fmt32_i(cfg_fmt32), .cfg_le_i(cfg_le), .cfg_sign_i(cfg_sign),
    .word_i(word), .word_valid_i(word_valid), .word_ready_o(word_ready),
    .rd_addr_o(rd_addr), .frame_req_i(frame_req), .frame_valid_o(frame_valid),
    .underrun_o(underrun), .left_o(left), .right_o(right)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int ci, int k);
    return {8'(k*37 + ci + 1), 8'(ci*3 + k*5 + 7), 8'(k*11 + ci*7), 8'(8'hA5 ^ 8'(k + ci))};
  endfunction

  // R6 / R7 / R8 expected sample
  function automatic logic [15:0] expect_smp(logic [31:0] w, logic f32, logic le, logic sg);
    logic [15:0] s;
    if (f32) s = le ? w[31:16] : {w[7:0], w[15:8]};
    else     s = le ? w[15:0]  : {w[7:0], w[15:8]};
    return s ^ {sg, 15'd0};
  endfunction

  task automatic push(logic [31:0] w);
    word = w;
    word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    exp_addr = exp_addr + (cfg_fmt32 ? 16'd4 : 16'd2);
  endtask

  task automatic request();
    frame_req = 1'b1;
    @(negedge clk);
    frame_req = 1'b0;
  endtask

  task automatic check_frame(string tag_fed);
    for (int l = 0; l < LANES; l++) begin
      string t;
      t = (l > int'(cfg_lanes)) ? "R5" : tag_fed;
      check(t, 32'(left[l*SW +: SW]), 32'(exp_l[l]));
      check((l > int'(cfg_lanes)) ? "R5" : (cfg_stereo ? tag_fed : "R4"),
            32'(right[l*SW +: SW]), 32'(exp_r[l]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", 32'(word_ready), 32'd1);
    check("R1", 32'(rd_addr), 32'd0);
    check("R1", 32'(frame_valid), 32'd0);
    check("R1", 32'(underrun), 32'd0);
    check("R1", 32'(left | right), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int ci = 0; ci < 64; ci++) begin
      int n;
      string tag;
      cfg_lanes  = 2'(ci);
      cfg_stereo = ci[2];
      cfg_fmt32  = ci[3];
      cfg_le     = ci[4];
      cfg_sign   = ci[5];
      tag = cfg_sign ? "R8" : (cfg_fmt32 ? "R7" : (cfg_le ? "R6" : (cfg_stereo ? "R3" : "R4")));
      n = (int'(cfg_lanes) + 1) * (cfg_stereo ? 2 : 1);
      for (int l = 0; l < LANES; l++) begin exp_l[l] = '0; exp_r[l] = '0; end
      for (int k = 0; k < n; k++) begin
        logic [31:0] w;
        w = mk(ci, k);
        if (cfg_stereo) begin
          if (k % 2 == 1) exp_r[k/2] = expect_smp(w, cfg_fmt32, cfg_le, cfg_sign);
          else            exp_l[k/2] = expect_smp(w, cfg_fmt32, cfg_le, cfg_sign);
        end else begin
          exp_l[k] = expect_smp(w, cfg_fmt32, cfg_le, cfg_sign);
        end
        check("R9", 32'(word_ready), 32'd1);
        push(w);
      end
      check("R9", 32'(word_ready), 32'd0);
      check("R2", 32'(rd_addr), 32'(exp_addr));
      request();
      check("R9", 32'(frame_valid), 32'd1);
      check("R9", 32'(underrun), 32'd0);
      check_frame(tag);
      @(negedge clk);
      check("R9", 32'(frame_valid), 32'd0);
      check("R9", 32'(word_ready), 32'd1);
    end

    // R10 underrun: two lanes stereo, 16-bit LE, no sign
    cfg_lanes = 2'd1; cfg_stereo = 1'b1; cfg_fmt32 = 1'b0; cfg_le = 1'b1; cfg_sign = 1'b0;
    push(32'hDEAD_1234);
    push(32'hBEEF_5678);
    request();
    check("R10", 32'(frame_valid), 32'd1);
    check("R10", 32'(underrun), 32'd1);
    check("R10", 32'(left | right), 32'd0);
    check("R10", 32'(word_ready), 32'd1);
    push(32'h0000_9ABC);
    push(32'hFFFF_DEF0);
    check("R10", 32'(word_ready), 32'd0);
    check("R2", 32'(rd_addr), 32'(exp_addr));
    request();
    check("R10", 32'(underrun), 32'd0);
    check("R10", 32'(left[15:0]),  32'h1234);
    check("R10", 32'(right[15:0]), 32'h5678);
    check("R10", 32'(left[31:16]), 32'h9ABC);
    check("R10", 32'(right[31:16]), 32'hDEF0);
    check("R5", 32'(left[63:32] | right[63:32]), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule